// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core (No Forwarding)

This block is a 32-bit integer core with five pipeline stages: fetch, decode, execute, memory and writeback. It runs an eight-instruction subset: add, sub, and, or, slt, lw, sw and beq. A register sits between each pair of stages and carries the instruction's operands and its control bits forward together. Instruction memory and data memory are small internal word arrays. They are filled through a simple load port before the program runs.

The core has no forwarding paths, no interlock and no flush. Software must space dependent instructions with nops, or reorder them. The destination-register choice is made in execute. The branch decision is formed in the memory stage, so the three instructions fetched after a beq always run. The register file writes through: a value written in writeback can be read in decode in the same cycle. Progress can be seen on the writeback, store and program-counter ports.

Top module: `p5_core`

## Requirements
- R1: While reset is high and in the cycle after it, `pc_out` is 0, and neither `wb_en` nor `dm_we` is asserted. After reset is released, the first instruction's writeback appears in the fourth cycle, and not before.
- R2: An R-type word (opcode 0x00) with funct 0x20/0x22/0x24/0x25/0x2A writes rs+rt, rs−rt, rs&rt, rs|rt, or a signed rs<rt result (1 or 0) into rd.
- R3: lw (opcode 0x23) writes the data word at byte address rs+sext(imm16) into rt. sw (opcode 0x2B) writes rt to that address. The word index is address bits [DAW+1:2]. A store never causes a register write, and a lw that follows a sw to the same address reads the stored value.
- R4: No forwarding. An instruction one or two slots after a writer reads the register's old value. An instruction three slots after reads the new value.
- R5: beq (opcode 0x04) is taken when rs equals rt, with target = PC+4+(sext(imm16)<<2). The three instructions fetched after it always execute. The target appears on `pc_out` in the cycle after the branch occupies the memory stage.
- R6: The write register is rd for R-type and rt for lw. Register 0 reads as zero and is never written, so `wb_en` stays low for it.
- R7: The all-zero word, and any unlisted opcode or funct, acts as a nop: no register write and no memory write.
- R8: When `load_we` is high, `load_data` is written to the instruction array (`load_to_imem`=1) or to the data array (`load_to_imem`=0), at word index `load_addr`.
- R9: The PC advances by 4 every cycle unless a taken branch redirects it. The pipeline never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Memory preload write strobe |
| load_to_imem | input | 1 | 1 selects instruction array, 0 data array |
| load_addr | input | LAW | Preload word index |
| load_data | input | 32 | Preload word |
| pc_out | output | 32 | Current fetch address |
| wb_en | output | 1 | Register write in writeback (never for register 0) |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 32 | Value being written |
| dm_we | output | 1 | Store in the memory stage this cycle |
| dm_addr | output | 32 | Byte address used by the memory stage |
| dm_wdata | output | 32 | Store data |

## Verification
Two functions can fall in the same cycle: the register write in writeback and the operand read in decode. This happens when the reader comes exactly three slots after the writer. The program triggers it with a writer followed by readers at distances one, two and three. The bench then checks that only the third reader sees the new value, both in the write stream and in the final registers. A store followed at once by a load from the same word also puts the memory write and the memory read in adjacent cycles, and the loaded value is compared. The branch redirect is judged from the `pc_out` trace and from the writes that the three exposed slots do and do not produce.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    mem_to_reg;
        logic    mem_write;
        logic    branch;
        logic    use_imm;
        logic    dst_is_rd;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] instr;
    } ifid_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] imm;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
    } idex_t;

    typedef struct packed {
        logic            reg_write;
        logic            mem_to_reg;
        logic            mem_write;
        logic            branch;
        logic            zero;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] alu_y;
        logic [XLEN-1:0] store_data;
        logic [RIDX-1:0] wreg;
    } exmem_t;

    typedef struct packed {
        logic            reg_write;
        logic            mem_to_reg;
        logic [XLEN-1:0] load_data;
        logic [XLEN-1:0] alu_y;
        logic [RIDX-1:0] wreg;
    } memwb_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [5:0] f_opcode(input logic [XLEN-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic [5:0] f_funct(input logic [XLEN-1:0] w);
        return w[5:0];
    endfunction
endpackage

// File: rtl/p5_decoder.sv
module p5_decoder
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl = '0;
                endcase
            end
            OPC_LW: begin
                ctrl.reg_write  = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            OPC_SW: begin
                ctrl.mem_write = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/p5_alu.sv
module p5_alu
    import pipe5_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
    parameter  int NREG = 32,
    parameter  int W    = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // write-through: a same-cycle write is seen by the decode read
    always_comb begin
        if (ra1 == '0)                     rd1 = '0;
        else if (we && (waddr == ra1))     rd1 = wdata;
        else                               rd1 = regs[ra1];
        if (ra2 == '0)                     rd2 = '0;
        else if (we && (waddr == ra2))     rd2 = wdata;
        else                               rd2 = regs[ra2];
    end

    // R6
    r0_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ra1 == '0) |-> (rd1 == '0));

    // R4
    wr_through_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0) && (waddr == ra2)) |-> (rd2 == wdata));
endmodule

// File: rtl/p5_core.sv
module p5_core
    import pipe5_pkg::*;
#(
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_we,
    input  logic            load_to_imem,
    input  logic [LAW-1:0]  load_addr,
    input  logic [XLEN-1:0] load_data,
    output logic [XLEN-1:0] pc_out,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            dm_we,
    output logic [XLEN-1:0] dm_addr,
    output logic [XLEN-1:0] dm_wdata
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q;
    ifid_t           ifid_q;
    idex_t           idex_q;
    exmem_t          exmem_q;
    memwb_t          memwb_q;

    // ---------------- fetch ----------------
    logic [XLEN-1:0] fetch_word;
    logic [XLEN-1:0] pc_plus4;
    logic            br_taken;
    logic [XLEN-1:0] pc_next;

    assign fetch_word = imem[pc_q[IAW+1:2]];
    assign pc_plus4   = pc_q + STEP;
    assign br_taken   = exmem_q.branch & exmem_q.zero;
    assign pc_next    = br_taken ? exmem_q.target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (load_we && load_to_imem) imem[load_addr[IAW-1:0]] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (rst) ifid_q <= '0;
        else     ifid_q <= '{pc4: pc_plus4, instr: fetch_word};
    end

    // ---------------- decode ----------------
    ctrl_t           id_ctrl;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic            wb_write;
    logic [XLEN-1:0] wb_value;

    p5_decoder u_dec (
        .opcode (f_opcode(ifid_q.instr)),
        .funct  (f_funct(ifid_q.instr)),
        .ctrl   (id_ctrl)
    );

    p5_regfile #(.NREG(32), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_write),
        .waddr (memwb_q.wreg),
        .wdata (wb_value),
        .ra1   (ifid_q.instr[25:21]),
        .ra2   (ifid_q.instr[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q <= '0;
        end else begin
            idex_q.ctrl <= id_ctrl;
            idex_q.pc4  <= ifid_q.pc4;
            idex_q.opa  <= rs_val;
            idex_q.opb  <= rt_val;
            idex_q.imm  <= sext16(ifid_q.instr[15:0]);
            idex_q.rt   <= ifid_q.instr[20:16];
            idex_q.rd   <= ifid_q.instr[15:11];
        end
    end

    // ---------------- execute ----------------
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [RIDX-1:0] ex_wreg;
    logic [XLEN-1:0] ex_target;

    assign alu_b     = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.opb;
    assign ex_wreg   = idex_q.ctrl.dst_is_rd ? idex_q.rd : idex_q.rt;
    assign ex_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

    p5_alu #(.W(XLEN)) u_alu (
        .a    (idex_q.opa),
        .b    (alu_b),
        .op   (idex_q.ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exmem_q <= '0;
        end else begin
            exmem_q.reg_write  <= idex_q.ctrl.reg_write;
            exmem_q.mem_to_reg <= idex_q.ctrl.mem_to_reg;
            exmem_q.mem_write  <= idex_q.ctrl.mem_write;
            exmem_q.branch     <= idex_q.ctrl.branch;
            exmem_q.zero       <= alu_zero;
            exmem_q.target     <= ex_target;
            exmem_q.alu_y      <= alu_y;
            exmem_q.store_data <= idex_q.opb;
            exmem_q.wreg       <= ex_wreg;
        end
    end

    // ---------------- memory ----------------
    logic [DAW-1:0]  dm_idx;
    logic [XLEN-1:0] dm_rdata;

    assign dm_idx   = exmem_q.alu_y[DAW+1:2];
    assign dm_rdata = dmem[dm_idx];

    always_ff @(posedge clk) begin
        if (load_we && !load_to_imem)  dmem[load_addr[DAW-1:0]] <= load_data;
        else if (exmem_q.mem_write)    dmem[dm_idx] <= exmem_q.store_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            memwb_q <= '0;
        end else begin
            memwb_q.reg_write  <= exmem_q.reg_write;
            memwb_q.mem_to_reg <= exmem_q.mem_to_reg;
            memwb_q.load_data  <= dm_rdata;
            memwb_q.alu_y      <= exmem_q.alu_y;
            memwb_q.wreg       <= exmem_q.wreg;
        end
    end

    // ---------------- writeback ----------------
    assign wb_write = memwb_q.reg_write;
    assign wb_value = memwb_q.mem_to_reg ? memwb_q.load_data : memwb_q.alu_y;

    assign pc_out   = pc_q;
    assign wb_en    = memwb_q.reg_write && (memwb_q.wreg != '0);
    assign wb_reg   = memwb_q.wreg;
    assign wb_data  = wb_value;
    assign dm_we    = exmem_q.mem_write;
    assign dm_addr  = exmem_q.alu_y;
    assign dm_wdata = exmem_q.store_data;

    logic unused_shamt;
    assign unused_shamt = ^ifid_q.instr[10:6];

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0) && !wb_en && !dm_we);

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !br_taken |=> (pc_q == $past(pc_q) + STEP));

    // R5
    br_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (pc_q == $past(exmem_q.target)));

    // R7
    nop_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (ifid_q.instr == '0) |=> (idex_q.ctrl == '0));

    // R3
    store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        exmem_q.mem_write |=> !memwb_q.reg_write);
endmodule

// File: tb/test_p5_core.sv
module test_p5_core;
    localparam int NPROG = 28;
    localparam int RUN   = 44;
    localparam int STEPS = 36;

    function automatic logic [31:0] r_op(input int fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction
    function automatic logic [31:0] i_op(input int op, input int rt, input int rs, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    localparam logic [31:0] PROG [NPROG] = '{
        i_op('h23, 1, 0, 0),        //  0 lw  $1,0($0)
        i_op('h23, 2, 0, 4),        //  1 lw  $2,4($0)
        i_op('h23, 3, 0, 8),        //  2 lw  $3,8($0)
        32'h0,                      //  3 nop
        r_op('h20, 4, 1, 2),        //  4 add $4,$1,$2
        r_op('h22, 5, 1, 2),        //  5 sub
        r_op('h24, 6, 1, 3),        //  6 and
        r_op('h25, 7, 2, 3),        //  7 or
        r_op('h2A, 8, 3, 1),        //  8 slt -5<7
        r_op('h2A, 9, 1, 3),        //  9 slt 7<-5
        r_op('h20, 12, 1, 1),       // 10 writer $12
        r_op('h20, 13, 12, 0),      // 11 slot 1: stale
        r_op('h20, 14, 12, 0),      // 12 slot 2: stale
        r_op('h20, 15, 12, 0),      // 13 slot 3: fresh
        i_op('h2B, 4, 0, 12),       // 14 sw $4,12($0)
        i_op('h23, 16, 0, 12),      // 15 lw $16,12($0)
        i_op('h04, 2, 1, 9),        // 16 beq not taken
        i_op('h04, 4, 4, 6),        // 17 beq taken -> 24
        r_op('h20, 17, 1, 0),       // 18 exposed slot
        r_op('h20, 18, 2, 0),       // 19 exposed slot
        r_op('h20, 19, 16, 0),      // 20 exposed slot
        r_op('h20, 20, 1, 1),       // 21 skipped
        i_op('h2B, 1, 0, 0),        // 22 skipped store
        r_op('h20, 21, 1, 1),       // 23 skipped
        r_op('h20, 0, 1, 1),        // 24 write to $0
        i_op('h2B, 5, 0, 16),       // 25 sw $5,16($0)
        i_op('h23, 22, 0, 16),      // 26 lw $22,16($0)
        32'h0                       // 27 nop
    };

    localparam int NEXP = 20;
    localparam int          EXP_REG [NEXP] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 12,
                                              13, 14, 15, 16, 17, 18, 19, 20, 21, 22};
    localparam logic [31:0] EXP_VAL [NEXP] = '{32'd7, 32'd3, 32'hFFFF_FFFB, 32'd10, 32'd4,
                                              32'd3, 32'hFFFF_FFFB, 32'd1, 32'd0, 32'd14,
                                              32'd0, 32'd0, 32'd14, 32'd10, 32'd7,
                                              32'd3, 32'd10, 32'd0, 32'd0, 32'd4};
    // requirement per row: R8 R3 R3 R2 R2 R2 R2 R2 R2 R2 R4 R4 R4 R3 R5 R5 R5 R5 R5 R3
    localparam int          EXP_REQ [NEXP] = '{8, 3, 3, 2, 2, 2, 2, 2, 2, 2,
                                              4, 4, 4, 3, 5, 5, 5, 5, 5, 3};

    logic        clk = 1'b0;
    logic        rst;
    logic        load_we;
    logic        load_to_imem;
    logic [5:0]  load_addr;
    logic [31:0] load_data;
    logic [31:0] pc_out;
    logic        wb_en;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic        dm_we;
    logic [31:0] dm_addr;
    logic [31:0] dm_wdata;

    always #5 clk = ~clk;

    p5_core i_p5_core (
        .clk(clk), .rst(rst), .load_we(load_we), .load_to_imem(load_to_imem),
        .load_addr(load_addr), .load_data(load_data), .pc_out(pc_out),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
    );

    int nchecks = 0;
    int nerr    = 0;
    bit done    = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dm_init(input int i);
        case (i)
            0: return 32'd7;
            1: return 32'd3;
            2: return 32'hFFFF_FFFB;
            default: return 32'd0;
        endcase
    endfunction

    // reference model: delayed register visibility and three exposed branch slots
    int          exp_wreg [64];
    logic [31:0] exp_wval [64];
    int          n_exp = 0;
    logic [31:0] exp_sa [8];
    logic [31:0] exp_sv [8];
    int          n_exp_st = 0;

    task automatic run_model();
        logic [31:0] m_reg [32];
        logic [31:0] m_mem [64];
        logic        pw_en [3];
        int          pw_reg [3];
        logic [31:0] pw_val [3];
        int idx = 0, tgt = 0, cnt = 0;
        bit pend = 0;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = dm_init(i);
        for (int i = 0; i < 3; i++) begin pw_en[i] = 0; pw_reg[i] = 0; pw_val[i] = '0; end
        for (int s = 0; s < STEPS; s++) begin
            logic [31:0] w, a, b, se, val, ad;
            int rs, rt, rd, r;
            logic en;
            w  = (idx < NPROG) ? PROG[idx] : 32'h0;
            if (pw_en[2] && pw_reg[2] != 0) m_reg[pw_reg[2]] = pw_val[2];
            rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
            a  = m_reg[rs]; b = m_reg[rt];
            se = {{16{w[15]}}, w[15:0]};
            ad = a + se;
            en = 0; r = 0; val = '0;
            case (w[31:26])
                6'h00: begin
                    en = 1; r = rd;
                    case (w[5:0])
                        6'h20: val = a + b;
                        6'h22: val = a - b;
                        6'h24: val = a & b;
                        6'h25: val = a | b;
                        6'h2A: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                        default: en = 0;
                    endcase
                end
                6'h23: begin en = 1; r = rt; val = m_mem[ad[7:2]]; end
                6'h2B: begin
                    m_mem[ad[7:2]] = b;
                    exp_sa[n_exp_st] = ad; exp_sv[n_exp_st] = b; n_exp_st++;
                end
                6'h04: if (a == b) begin pend = 1; cnt = 3; tgt = idx + 1 + int'($signed(se)); end
                default: en = 0;
            endcase
            pw_en[2] = pw_en[1]; pw_reg[2] = pw_reg[1]; pw_val[2] = pw_val[1];
            pw_en[1] = pw_en[0]; pw_reg[1] = pw_reg[0]; pw_val[1] = pw_val[0];
            pw_en[0] = en;       pw_reg[0] = r;         pw_val[0] = val;
            if (en && r != 0) begin exp_wreg[n_exp] = r; exp_wval[n_exp] = val; n_exp++; end
            if (pend) begin
                if (cnt == 0) begin idx = tgt; pend = 0; end
                else begin cnt--; idx++; end
            end else begin
                idx++;
            end
        end
    endtask

    int          got_wreg [64];
    logic [31:0] got_wval [64];
    int          n_got = 0;
    logic [31:0] got_sa [8];
    logic [31:0] got_sv [8];
    int          n_st = 0;
    logic [31:0] pcs [RUN];
    logic [31:0] fin [32];

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchecks++; nerr++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_we = 1'b0; load_to_imem = 1'b0; load_addr = '0; load_data = '0;
        repeat (2) @(negedge clk);
        // R8: preload both arrays through the load port
        for (int i = 0; i < 64; i++) begin
            load_we = 1'b1; load_to_imem = 1'b1; load_addr = i[5:0];
            load_data = (i < NPROG) ? PROG[i] : 32'h0;
            @(negedge clk);
        end
        for (int i = 0; i < 64; i++) begin
            load_we = 1'b1; load_to_imem = 1'b0; load_addr = i[5:0];
            load_data = dm_init(i);
            @(negedge clk);
        end
        load_we = 1'b0;
        @(negedge clk);
        chk("R1", "pc in reset", pc_out, 32'h0);
        chk("R1", "wb_en in reset", {31'h0, wb_en}, 32'h0);
        chk("R1", "dm_we in reset", {31'h0, dm_we}, 32'h0);

        run_model();
        rst = 1'b0;
        for (int k = 0; k < RUN; k++) begin
            @(negedge clk);
            pcs[k] = pc_out;
            if (k < 3) chk("R1", "early writeback", {31'h0, wb_en}, 32'h0);
            if (wb_en) begin
                chk("R6", "wb to register 0", {27'h0, wb_reg} == 0 ? 32'h1 : 32'h0, 32'h0);
                got_wreg[n_got] = int'(wb_reg); got_wval[n_got] = wb_data; n_got++;
            end
            if (dm_we) begin
                got_sa[n_st] = dm_addr; got_sv[n_st] = dm_wdata; n_st++;
            end
        end

        // R9 / R5: PC trace
        chk("R9", "first pc", pcs[0], 32'd4);
        for (int k = 1; k < RUN; k++) begin
            if (pcs[k-1] == 32'd80) chk("R5", "branch redirect pc", pcs[k], 32'd96);
            else                    chk("R9", "pc step", pcs[k], pcs[k-1] + 32'd4);
        end

        // R7: write count matches the model (nops, skipped slots write nothing)
        chk("R7", "writeback count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk("R2", "write stream reg", got_wreg[i], exp_wreg[i]);
            chk("R2", "write stream value", got_wval[i], exp_wval[i]);
        end

        // R3 / R5: stores, including the skipped one
        chk("R5", "store count", n_st, 32'd2);
        chk("R3", "model store count", n_st, n_exp_st);
        if (n_st >= 2) begin
            chk("R3", "store0 addr", got_sa[0], 32'd12);
            chk("R3", "store0 data", got_sv[0], 32'd10);
            chk("R3", "store1 addr", got_sa[1], 32'd16);
            chk("R3", "store1 data", got_sv[1], 32'd4);
        end

        // final register contents, rebuilt from the writeback stream
        for (int i = 0; i < 32; i++) fin[i] = '0;
        for (int i = 0; i < n_got; i++) fin[got_wreg[i]] = got_wval[i];
        for (int i = 0; i < NEXP; i++) begin
            nchecks++;
            if (fin[EXP_REG[i]] !== EXP_VAL[i]) begin
                nerr++;
                $display("FAIL R%0d reg %0d actual=%h expected=%h",
                         EXP_REQ[i], EXP_REG[i], fin[EXP_REG[i]], EXP_VAL[i]);
            end
        end

        // R1: reset asserted again mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "pc after re-reset", pc_out, 32'h0);
        chk("R1", "wb_en after re-reset", {31'h0, wb_en}, 32'h0);
        chk("R1", "dm_we after re-reset", {31'h0, dm_we}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule